// File: doc/BRIEF.md
# Status-coded I2C byte master

This block is an I2C master that software drives one bus event at a time. A write to the control register with the bus-enable bit set and the interrupt-flag bit clear starts the next event. That event is a START, a repeated START, an address byte, a data byte sent or received, or a STOP. When the event ends, the block sets the interrupt flag and posts an 8-bit status code. Software reads that code to choose the next step. Only master operation with 7-bit addresses is covered.

SCL and SDA are open-drain. Each line is brought out as an active-high pull-low enable plus an input that returns the resolved line level. A separate interrupt register holds the interrupt enable and two manual line overrides. Software uses the overrides to clock a stuck target free and then place a STOP on the bus. Each bit on the bus takes four quarters of `QTR_CYC` clock cycles. A target that holds SCL low while the master has released it stretches the clock.

Top module: `i2c_evt_master`

## Requirements
- R1: After reset the status reads 0xF8, the control register and data register read 0, the interrupt flag is clear, both line enables are low and the interrupt output is low.
- R2: `reg_sel` = 1 selects the control register, with bit 7 clock enable, bit 6 bus enable, bit 5 START request, bit 4 STOP request, bit 3 interrupt flag and bit 2 assert-acknowledge. Writing 0 to bit 3 clears the flag and writing 1 leaves it unchanged. A write with bit 6 = 1 and bit 3 = 0 launches the next event.
- R3: A START request posts 0x08 when the bus is free and 0x10 when the bus is already held (repeated START). In both cases it sets the flag and clears the request bit.
- R4: In status 0x08 or 0x10, a launch sends the data register (`reg_sel` = 0) MSB first as the address byte, where bit 0 = 1 means read. The outcome posts 0x18 for a write ACK, 0x20 for a write NACK, 0x40 for a read ACK and 0x48 for a read NACK.
- R5: In status 0x18, 0x20, 0x28 or 0x30, a launch sends the data register MSB first and posts 0x28 on ACK or 0x30 on NACK.
- R6: In status 0x40 or 0x50, a launch receives a byte. With assert-acknowledge set the master sends ACK and posts 0x50; with it clear the master sends NACK and posts 0x58. The byte is in the data register by the time the flag sets.
- R7: A STOP request while the bus is held places a STOP on the bus, returns the status to 0xF8, leaves the flag clear, releases both lines and clears the request bits.
- R8: A START request while the bus is free and SDA is low is refused. The status stays 0xF8, the flag stays clear, the request bit clears and neither line is driven.
- R9: The interrupt output is high exactly when bit 6 of the interrupt register (`reg_sel` = 2) is set and the status is not 0xF8.
- R10: Interrupt-register bit 9 pulls SCL low and bit 8 pulls SDA low, independent of the engine.
- R11: While an event is in progress, writes to the control and data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 data, 1 control, 2 interrupt register |
| reg_wdata | input | 10 | Write value |
| data_q | output | 8 | Data register |
| ctrl_q | output | 8 | Control register including interrupt flag |
| status_q | output | 8 | Status code |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The assertions assume that software launches a new event only while the flag is set or the bus is idle. They also assume that STOP is requested only after a START. The stimulus always waits for the flag, or for a fixed settle time after a STOP or a refused START, before it issues the next control write. The bench target changes SDA only while SCL is low, so the START and STOP conditions on the bus come only from the master or from the override sequence. The stuck-bus case holds SDA low until nine falling SCL edges have passed.

// File: rtl/i2c_evt_master.sv
module i2c_evt_master #(
  parameter int QTR_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [9:0] reg_wdata,
  output logic [7:0] data_q,
  output logic [7:0] ctrl_q,
  output logic [7:0] status_q,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CW = (QTR_CYC > 2) ? $clog2(QTR_CYC) : 1;
  localparam logic [7:0] ST_START  = 8'h08, ST_RSTART = 8'h10,
                         ST_WA_ACK = 8'h18, ST_WA_NAK = 8'h20,
                         ST_WD_ACK = 8'h28, ST_WD_NAK = 8'h30,
                         ST_RA_ACK = 8'h40, ST_RA_NAK = 8'h48,
                         ST_RD_ACK = 8'h50, ST_RD_NAK = 8'h58,
                         ST_IDLE   = 8'hF8;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BYTE, PH_STOP} phase_t;
  typedef enum logic [1:0] {K_ADDR, K_TX, K_RX} kind_t;

  phase_t phase, l_phase;
  kind_t  kind, l_kind;
  logic [CW-1:0] cnt;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh, status, data;
  logic ce, en, sta, stp, aak, iflg, busy, rd_mode, ack_bit;
  logic int_en, ovr_scl, ovr_sda, eng_scl, eng_sda;
  logic l_refuse;

  wire stall = (q == 2'd1) && !eng_scl && !scl_in;
  wire tick  = (phase != PH_IDLE) && (cnt == CW'(QTR_CYC - 1)) && !stall;
  wire ctl_wr = reg_wr && reg_sel == 2'd1 && phase == PH_IDLE;
  wire dat_wr = reg_wr && reg_sel == 2'd0 && phase == PH_IDLE;
  wire int_wr = reg_wr && reg_sel == 2'd2;
  wire go = ctl_wr && reg_wdata[6] && !reg_wdata[3];
  wire [7:0] sh_nx = {sh[6:0], 1'b0};

  function automatic logic bit_drive(input logic [3:0] b, input kind_t k,
                                     input logic [7:0] s, input logic a);
    if (b == 4'd8) return (k == K_RX) ? a : 1'b0;
    return (k == K_RX) ? 1'b0 : !s[7];
  endfunction

  always_comb begin
    l_phase = PH_IDLE;
    l_kind = K_TX;
    l_refuse = 1'b0;
    if (go) begin
      if (reg_wdata[5]) begin
        if (busy || sda_in) l_phase = PH_START;
        else l_refuse = 1'b1;
      end else if (reg_wdata[4]) begin
        if (busy) l_phase = PH_STOP;
      end else if (status == ST_START || status == ST_RSTART) begin
        l_phase = PH_BYTE;
        l_kind = K_ADDR;
      end else if (status == ST_WA_ACK || status == ST_WA_NAK ||
                   status == ST_WD_ACK || status == ST_WD_NAK) begin
        l_phase = PH_BYTE;
        l_kind = K_TX;
      end else if (status == ST_RA_ACK || status == ST_RD_ACK) begin
        l_phase = PH_BYTE;
        l_kind = K_RX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; kind <= K_TX; cnt <= '0; q <= 2'd0; bitn <= 4'd0;
      sh <= 8'h00; status <= ST_IDLE; data <= 8'h00;
      ce <= 1'b0; en <= 1'b0; sta <= 1'b0; stp <= 1'b0; aak <= 1'b0;
      iflg <= 1'b0; busy <= 1'b0; rd_mode <= 1'b0; ack_bit <= 1'b0;
      int_en <= 1'b0; ovr_scl <= 1'b0; ovr_sda <= 1'b0;
      eng_scl <= 1'b0; eng_sda <= 1'b0;
    end else begin
      if (int_wr) begin
        int_en <= reg_wdata[6];
        ovr_scl <= reg_wdata[9];
        ovr_sda <= reg_wdata[8];
      end
      if (dat_wr) data <= reg_wdata[7:0];
      if (ctl_wr) begin
        ce <= reg_wdata[7]; en <= reg_wdata[6]; sta <= reg_wdata[5];
        stp <= reg_wdata[4]; aak <= reg_wdata[2];
        if (!reg_wdata[3]) iflg <= 1'b0;
        if (l_refuse) sta <= 1'b0;
        if (go && reg_wdata[4] && !reg_wdata[5] && !busy) stp <= 1'b0;
      end

      if (phase == PH_IDLE) begin
        cnt <= '0;
        q <= 2'd0;
        if (l_phase != PH_IDLE) begin
          phase <= l_phase;
          kind <= l_kind;
          bitn <= 4'd0;
          case (l_phase)
            PH_START: eng_sda <= 1'b0;
            PH_STOP:  eng_sda <= 1'b1;
            default: begin
              sh <= data;
              if (l_kind == K_ADDR) rd_mode <= data[0];
              eng_sda <= bit_drive(4'd0, l_kind, data, reg_wdata[2]);
            end
          endcase
        end
      end else if (!tick) begin
        if (!stall) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        q <= q + 2'd1;
        case (q)
          2'd0: eng_scl <= 1'b0;
          2'd1: begin
            if (phase == PH_START) eng_sda <= 1'b1;
            if (phase == PH_STOP)  eng_sda <= 1'b0;
            if (phase == PH_BYTE) begin
              if (bitn == 4'd8) ack_bit <= !sda_in;
              else if (kind == K_RX) sh <= {sh[6:0], sda_in};
            end
          end
          2'd2: if (phase != PH_STOP) eng_scl <= 1'b1;
          default: begin
            case (phase)
              PH_START: begin
                status <= busy ? ST_RSTART : ST_START;
                busy <= 1'b1; iflg <= 1'b1; sta <= 1'b0; phase <= PH_IDLE;
              end
              PH_STOP: begin
                status <= ST_IDLE;
                busy <= 1'b0; sta <= 1'b0; stp <= 1'b0; phase <= PH_IDLE;
              end
              default: begin
                if (bitn != 4'd8) begin
                  bitn <= bitn + 4'd1;
                  if (kind != K_RX) sh <= sh_nx;
                  eng_sda <= bit_drive(bitn + 4'd1, kind, sh_nx, aak);
                end else begin
                  eng_sda <= 1'b0;
                  iflg <= 1'b1;
                  phase <= PH_IDLE;
                  case (kind)
                    K_ADDR: status <= rd_mode ? (ack_bit ? ST_RA_ACK : ST_RA_NAK)
                                              : (ack_bit ? ST_WA_ACK : ST_WA_NAK);
                    K_TX:   status <= ack_bit ? ST_WD_ACK : ST_WD_NAK;
                    default: begin
                      status <= aak ? ST_RD_ACK : ST_RD_NAK;
                      data <= sh;
                    end
                  endcase
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  assign data_q   = data;
  assign status_q = status;
  assign ctrl_q   = {ce, en, sta, stp, iflg, aak, 2'b00};
  assign irq      = int_en && (status != ST_IDLE);
  assign scl_oe   = eng_scl | ovr_scl;
  assign sda_oe   = eng_sda | ovr_sda;

  // R3
  iflg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && !(reg_wr && reg_sel == 2'd1)) |=> iflg);
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status == ST_IDLE && !eng_scl && !eng_sda));
  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && phase == PH_IDLE) |-> (!eng_scl && !eng_sda));
  // R6
  data_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> (iflg || $past(reg_wr && reg_sel == 2'd0)));
  // R2
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iflg |-> status != ST_IDLE);
  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_IDLE || status == ST_START || status == ST_RSTART ||
    status == ST_WA_ACK || status == ST_WA_NAK || status == ST_WD_ACK ||
    status == ST_WD_NAK || status == ST_RA_ACK || status == ST_RA_NAK ||
    status == ST_RD_ACK || status == ST_RD_NAK);
endmodule

// File: tb/i2c_evt_master_bench.sv
module i2c_evt_master_bench;
  localparam int CLK_PER = 10;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [9:0] reg_wdata = 10'd0;
  wire [7:0] data_q, ctrl_q, status_q;
  wire irq, scl_oe, sda_oe;
  logic s_drive = 1'b0, stuck = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe | s_drive | stuck);

  i2c_evt_master u_i2c_evt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .data_q(data_q), .ctrl_q(ctrl_q),
    .status_q(status_q), .irq(irq), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  int checks = 0, fails = 0;
  int bitcnt = 0, stop_cnt = 0, stuck_cnt = 0;
  logic [7:0] ssh = 8'h00, wlog = 8'h00, txb = 8'h00;
  logic addr_ph = 1'b0, rd_ph = 1'b0, matched = 1'b0, dack_en = 1'b1, mack = 1'b0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    bitcnt = 0; addr_ph = 1'b1; rd_ph = 1'b0; matched = 1'b0; s_drive = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    stop_cnt++; addr_ph = 1'b0; rd_ph = 1'b0; matched = 1'b0; s_drive = 1'b0;
  end
  always @(posedge scl_line) begin
    if (!rd_ph || bitcnt == 8) begin
      if (bitcnt < 8) ssh = {ssh[6:0], sda_line};
      else mack = !sda_line;
    end
    bitcnt++;
  end
  always @(negedge scl_line) begin
    if (stuck) begin
      stuck_cnt++;
      if (stuck_cnt == 9) stuck = 1'b0;
    end
    if (bitcnt == 8) begin
      if (addr_ph) s_drive = (ssh[7:1] == SLV);
      else if (matched && !rd_ph) begin s_drive = dack_en; wlog = ssh; end
      else s_drive = 1'b0;
    end else if (bitcnt == 9) begin
      bitcnt = 0;
      if (addr_ph) begin
        addr_ph = 1'b0; matched = (ssh[7:1] == SLV);
        rd_ph = matched && ssh[0]; txb = 8'hA5; s_drive = rd_ph && !txb[7];
      end else if (rd_ph && mack) begin
        txb = txb + 8'd1; s_drive = !txb[7];
      end else begin
        s_drive = 1'b0; rd_ph = 1'b0;
      end
    end else if (rd_ph && bitcnt >= 1 && bitcnt <= 7) s_drive = !txb[3'(7 - bitcnt)];
    else if (!rd_ph) s_drive = 1'b0;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [9:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 2000; i++) begin
      if (ctrl_q[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic step(input bit wr_d, input logic [7:0] d, input logic [7:0] c,
                      input logic [7:0] exp, input string req);
    if (wr_d) wr(2'd0, {2'b00, d});
    wr(2'd1, {2'b00, c});
    wait_flag();
    chk(status_q == exp && ctrl_q[3], req, {2'b00, status_q}, {2'b00, exp});
  endtask

  task automatic do_stop(input string req);
    int sc;
    sc = stop_cnt;
    wr(2'd1, 10'h050);
    repeat (60) @(negedge clk);
    chk(status_q == 8'hF8 && !ctrl_q[3] && ctrl_q[5:4] == 2'b00, req, {2'b00, status_q}, 10'h0F8);
    chk(!scl_oe && !sda_oe && stop_cnt == sc + 1, req, {8'h00, scl_oe, sda_oe}, 10'h000);
  endtask

  task automatic t_reset();
    chk(status_q == 8'hF8, "R1 status", {2'b00, status_q}, 10'h0F8);
    chk(ctrl_q == 8'h00 && data_q == 8'h00, "R1 regs", {2'b00, ctrl_q}, 10'h000);
    chk(!irq && !scl_oe && !sda_oe, "R1 outputs", {7'h0, irq, scl_oe, sda_oe}, 10'h000);
  endtask

  task automatic t_ctrl_bits();
    wr(2'd1, 10'h0C4);
    repeat (20) @(negedge clk);
    chk(ctrl_q == 8'hC4 && status_q == 8'hF8, "R2 bit positions", {2'b00, ctrl_q}, 10'h0C4);
    wr(2'd1, 10'h000);
  endtask

  task automatic t_write();
    step(1'b0, 8'h00, 8'h60, 8'h08, "R3 start");
    chk(ctrl_q[5] == 1'b0, "R3 start bit cleared", {9'h0, ctrl_q[5]}, 10'h000);
    wr(2'd1, 10'h048);
    chk(ctrl_q[3] == 1'b1, "R2 flag write-one keeps", {9'h0, ctrl_q[3]}, 10'h001);
    step(1'b1, {SLV, 1'b0}, 8'h40, 8'h18, "R4 write address ack");
    step(1'b1, 8'h3C, 8'h40, 8'h28, "R5 data ack");
    chk(wlog == 8'h3C, "R5 byte on bus", {2'b00, wlog}, 10'h03C);
    dack_en = 1'b0;
    step(1'b1, 8'h11, 8'h40, 8'h30, "R5 data nack");
    dack_en = 1'b1;
    do_stop("R7 stop after write");
  endtask

  task automatic t_addr_nack();
    step(1'b0, 8'h00, 8'h60, 8'h08, "R3 start again");
    step(1'b1, 8'h44, 8'h40, 8'h20, "R4 write address nack");
    step(1'b0, 8'h00, 8'h60, 8'h10, "R3 repeated start");
    step(1'b1, 8'h45, 8'h40, 8'h48, "R4 read address nack");
    do_stop("R7 stop after nack");
  endtask

  task automatic t_read();
    step(1'b0, 8'h00, 8'h60, 8'h08, "R3 start read");
    step(1'b1, {SLV, 1'b1}, 8'h40, 8'h40, "R4 read address ack");
    step(1'b0, 8'h00, 8'h44, 8'h50, "R6 byte with ack");
    chk(data_q == 8'hA5 && mack, "R6 first byte and master ack", {2'b00, data_q}, 10'h0A5);
    step(1'b0, 8'h00, 8'h40, 8'h58, "R6 byte with nack");
    chk(data_q == 8'hA6 && !mack, "R6 last byte and master nack", {2'b00, data_q}, 10'h0A6);
    do_stop("R7 stop after read");
  endtask

  task automatic t_busy_ignore();
    step(1'b0, 8'h00, 8'h60, 8'h08, "R11 start");
    wr(2'd0, {2'b00, SLV, 1'b0});
    wr(2'd1, 10'h040);
    repeat (10) @(negedge clk);
    wr(2'd0, 10'h077);
    wr(2'd1, 10'h044);
    chk(ctrl_q == 8'h40 && data_q == {SLV, 1'b0}, "R11 writes ignored", {2'b00, ctrl_q}, 10'h040);
    wait_flag();
    chk(status_q == 8'h18, "R11 phase completes", {2'b00, status_q}, 10'h018);
    do_stop("R7 stop after busy");
  endtask

  task automatic t_irq();
    wr(2'd2, 10'h040);
    chk(!irq, "R9 idle no irq", {9'h0, irq}, 10'h000);
    step(1'b0, 8'h00, 8'h60, 8'h08, "R9 start");
    chk(irq, "R9 irq on status", {9'h0, irq}, 10'h001);
    wr(2'd2, 10'h000);
    chk(!irq, "R9 irq masked", {9'h0, irq}, 10'h000);
    wr(2'd2, 10'h040);
    do_stop("R9 stop");
    chk(!irq, "R9 irq off at idle", {9'h0, irq}, 10'h000);
    wr(2'd2, 10'h000);
  endtask

  task automatic t_stuck();
    int sc;
    stuck = 1'b1;
    stuck_cnt = 0;
    wr(2'd1, 10'h060);
    repeat (200) @(negedge clk);
    chk(status_q == 8'hF8 && !ctrl_q[3] && !ctrl_q[5], "R8 start refused", {2'b00, status_q}, 10'h0F8);
    chk(!scl_oe && !sda_oe, "R8 no bus activity", {8'h0, scl_oe, sda_oe}, 10'h000);
    for (int i = 0; i < 9; i++) begin
      wr(2'd2, 10'h000);
      repeat (4) @(negedge clk);
      wr(2'd2, 10'h200);
      repeat (4) @(negedge clk);
    end
    chk(scl_oe && !sda_oe, "R10 scl override", {8'h0, scl_oe, sda_oe}, 10'h002);
    chk(!stuck, "R10 nine clocks free target", {9'h0, stuck}, 10'h000);
    sc = stop_cnt;
    wr(2'd2, 10'h300);
    repeat (4) @(negedge clk);
    chk(sda_oe && scl_oe, "R10 sda override", {8'h0, scl_oe, sda_oe}, 10'h003);
    wr(2'd2, 10'h100);
    repeat (4) @(negedge clk);
    wr(2'd2, 10'h000);
    repeat (4) @(negedge clk);
    chk(stop_cnt == sc + 1 && sda_line && scl_line, "R10 manual stop", {8'h0, scl_line, sda_line}, 10'h003);
    step(1'b0, 8'h00, 8'h60, 8'h08, "R8 start after recovery");
    do_stop("R7 stop after recovery");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_write();
    t_addr_nack();
    t_read();
    t_busy_ignore();
    t_irq();
    t_stuck();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    summary();
  end
endmodule